// File: doc/BRIEF.md
# SPI Configuration Status Poller

This block waits on the status register of an SPI configuration slave. After a start pulse it repeatedly fetches the slave's status byte and stops when one of three things happens. The first is that the slave reports a fault. The second is that the slave is idle and shows every condition the caller asked for. The third is that a cycle budget runs out.

Each status sample is two one-byte transfers of the read-status opcode. The slave places its status on the data line in the first byte of a chip-select frame, but the first answer may be stale. The block therefore issues the opcode twice, each byte in its own chip-select frame, and keeps only the second answer.

The block does not shift bits itself. It borrows a shared SPI byte engine through a request/grant pair. It keeps the request up while it issues both bytes of a sample, and releases the request between samples so that other users can get the bus. The caller sees a level `active` while polling. One sticky result flag and the last kept status byte remain valid until the next start.

Top module: `spi_status_poller`

## Requirements
- R1: After reset, `active`, `done`, `err`, `tmo`, `spi_req` and `spi_go` are low and `status` is 0x00.
- R2: A `start` pulse while idle clears all three result flags, captures `mask`, raises `active` and requests the engine. A `start` while `active` is ignored, and changes on `mask` after capture have no effect on the poll in progress.
- R3: Each sample issues two `spi_go` pulses, each one cycle long and only while `spi_req` and `spi_gnt` are high, with `spi_tx` = 0x00. The second pulse follows the `spi_ack` of the first. The byte returned with the first `spi_ack` is discarded.
- R4: `spi_req` stays high from the grant until the second `spi_ack` of a sample, and is low in the cycle after that acknowledge.
- R5: If the kept byte has bit 2 (protocol violation) or bit 3 (transfer error) set, the poll ends with `err`. This takes priority over success.
- R6: If the kept byte has bit 0 (busy) clear and every bit of the captured mask set, the poll ends with `done`. With a mask of zero, this means waiting until the slave is not busy. Bit 1 is the ready bit that callers normally place in the mask.
- R7: If a sample meets neither R5 nor R6, and at least `TMO_CYCLES` clock cycles have passed since the start, the poll ends with `tmo`. Otherwise a new sample begins.
- R8: `status` holds the most recent kept byte.
- R9: At most one of `done`, `err` and `tmo` is high. A flag stays high until the next accepted start, and no flag is high while `active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a poll (one-cycle pulse) |
| mask | input | 8 | Status bits that must be set for success |
| active | output | 1 | Poll in progress |
| done | output | 1 | Poll ended in success |
| err | output | 1 | Poll ended on a slave error bit |
| tmo | output | 1 | Poll ended by the cycle budget |
| status | output | 8 | Last kept status byte |
| spi_req | output | 1 | Request for the shared SPI byte engine |
| spi_gnt | input | 1 | Engine granted to this block |
| spi_go | output | 1 | Launch one framed byte transfer |
| spi_tx | output | 8 | Byte to send (read-status opcode) |
| spi_ack | input | 1 | Transfer complete, `spi_rx` valid (one-cycle pulse) |
| spi_rx | input | 8 | Byte received in the finished transfer |

## Verification
The assertions assume that the engine keeps `spi_gnt` high for as long as `spi_req` stays high once it has granted, and that it returns exactly one single-cycle `spi_ack` per `spi_go`, never unprompted. The bench engine model grants after a fixed delay, holds the grant until the request falls, and acknowledges each launch after a fixed latency. It feeds a deliberately faulty byte as every discarded first reply, so that a poller which keeps the wrong byte ends in error. Start pulses and mask changes during a poll stay on the block's own inputs and never disturb the engine handshake.

// File: rtl/spi_status_poller.sv
module spi_status_poller #(
  parameter int unsigned TMO_CYCLES = 500_000_000,
  parameter logic [7:0]  RD_OPCODE  = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] mask,
  output logic       active,
  output logic       done,
  output logic       err,
  output logic       tmo,
  output logic [7:0] status,
  output logic       spi_req,
  input  logic       spi_gnt,
  output logic       spi_go,
  output logic [7:0] spi_tx,
  input  logic       spi_ack,
  input  logic [7:0] spi_rx
);
  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TMO_CYCLES);
  localparam logic [7:0] BUSY_BIT = 8'h01;
  localparam logic [7:0] FAULT_BITS = 8'h0C;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_GO1, S_W1, S_GO2, S_W2, S_GAP} st_t;

  st_t           st;
  logic [7:0]    mask_q;
  logic [CW-1:0] cnt;

  wire expired = (cnt == LIMIT);
  wire fault   = |(spi_rx & FAULT_BITS);
  wire ok      = ((spi_rx & (BUSY_BIT | mask_q)) == mask_q);

  assign active  = (st != S_IDLE);
  assign spi_req = (st == S_REQ) || (st == S_GO1) || (st == S_W1) ||
                   (st == S_GO2) || (st == S_W2);
  assign spi_go  = (st == S_GO1) || (st == S_GO2);
  assign spi_tx  = RD_OPCODE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mask_q <= '0;
      cnt    <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
      tmo    <= 1'b0;
      status <= '0;
    end else begin
      if (st != S_IDLE && !expired) cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          mask_q <= mask;
          cnt    <= '0;
          done   <= 1'b0;
          err    <= 1'b0;
          tmo    <= 1'b0;
          st     <= S_REQ;
        end
        S_REQ: if (spi_gnt) st <= S_GO1;
        S_GO1: st <= S_W1;
        S_W1:  if (spi_ack) st <= S_GO2;
        S_GO2: st <= S_W2;
        S_W2: if (spi_ack) begin
          status <= spi_rx;
          if (fault) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else if (ok) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (expired) begin
            tmo <= 1'b1;
            st  <= S_IDLE;
          end else begin
            st <= S_GAP;
          end
        end
        S_GAP: st <= S_REQ;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module spi_status_poller_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       active,
  input logic       done,
  input logic       err,
  input logic       tmo,
  input logic [7:0] status,
  input logic       spi_req,
  input logic       spi_gnt,
  input logic       spi_go,
  input logic       spi_ack
);
  assert_go_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_go |-> (spi_req && spi_gnt));
  assert_go_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_go |=> !spi_go);
  assert_req_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_req) |-> $past(spi_ack));
  assert_req_in_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req |-> active);
  assert_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (status[2] || status[3]));
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!status[0] && !status[2] && !status[3]));
  assert_one_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err, tmo}));
  assert_flag_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err || tmo) |-> !active);
endmodule

bind spi_status_poller spi_status_poller_chk u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .done(done), .err(err),
  .tmo(tmo), .status(status), .spi_req(spi_req), .spi_gnt(spi_gnt),
  .spi_go(spi_go), .spi_ack(spi_ack)
);

// File: tb/sim_spi_status_poller.sv
`timescale 1ns/1ps
module sim_spi_status_poller;
  localparam int T = 60;
  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] mask = 0;
  logic active, done, err, tmo, spi_req, spi_go, spi_gnt = 0, spi_ack = 0;
  logic [7:0] status, spi_tx, spi_rx = 0;

  always #2 clk = ~clk;

  spi_status_poller #(.TMO_CYCLES(T)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mask(mask), .active(active),
    .done(done), .err(err), .tmo(tmo), .status(status), .spi_req(spi_req),
    .spi_gnt(spi_gnt), .spi_go(spi_go), .spi_tx(spi_tx), .spi_ack(spi_ack),
    .spi_rx(spi_rx));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit c, input string tag, input int act, input int exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // engine model
  logic [7:0] replies[$];
  int gwait = 0, alat = -1, nack = 0;
  logic ack_pend_first = 1;
  bit req_was = 0;

  // reference model
  bit m_act = 0, m_done = 0, m_err = 0, m_tmo = 0, m_after2 = 0;
  logic [7:0] m_mask = 0, m_stat = 0;
  int m_cyc = 0, m_acks = 0;

  always @(posedge clk) begin
    m_after2 = 0;
    if (!rst_n) begin
      m_act = 0; m_done = 0; m_err = 0; m_tmo = 0; m_stat = 0;
    end else if (!m_act) begin
      if (start) begin
        m_act = 1; m_mask = mask; m_done = 0; m_err = 0; m_tmo = 0;
        m_cyc = 0; m_acks = 0;
      end
    end else begin
      if (spi_ack) begin
        m_acks++;
        if (m_acks % 2 == 0) begin
          m_after2 = 1;
          m_stat = spi_rx;
          if (spi_rx & 8'h0C) begin m_err = 1; m_act = 0; end
          else if ((spi_rx & (8'h01 | m_mask)) == m_mask) begin m_done = 1; m_act = 0; end
          else if (m_cyc >= T) begin m_tmo = 1; m_act = 0; end
        end
      end
      m_cyc++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(active == m_act, "R2 active", active, m_act);
      chk(done == m_done, "R6 done", done, m_done);
      chk(err == m_err, "R5 err", err, m_err);
      chk(tmo == m_tmo, "R7 tmo", tmo, m_tmo);
      chk(status == m_stat, "R8 status", status, m_stat);
      if (m_after2) chk(!spi_req, "R4 req low after sample", spi_req, 0);
      if (spi_go) begin
        chk(spi_tx == 8'h00, "R3 opcode", spi_tx, 0);
        chk(spi_gnt && spi_req, "R3 go granted", spi_gnt, 1);
      end
      if (spi_gnt && !m_after2 && req_was && m_act)
        chk(spi_req || !m_act, "R4 req held", spi_req, 1);
    end
    // engine
    spi_ack = 0;
    if (!spi_req) begin spi_gnt = 0; gwait = 0; end
    else if (!spi_gnt) begin gwait++; if (gwait >= 2) spi_gnt = 1; end
    if (alat == 0) begin
      spi_ack = 1;
      nack++;
      if (nack % 2 == 1) spi_rx = 8'h0C;
      else spi_rx = (replies.size() > 0) ? replies.pop_front() : 8'h01;
      alat = -1;
    end else if (alat > 0) alat--;
    if (spi_go) alat = 2;
    req_was = spi_req;
  end

  task automatic poll(input logic [7:0] m, input int maxcyc);
    @(negedge clk); start = 1; mask = m;
    @(negedge clk); start = 0;
    for (int i = 0; i < maxcyc && m_act; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #20000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({active, done, err, tmo, spi_req, spi_go} == 6'b0, "R1 reset outputs",
        {active, done, err, tmo, spi_req, spi_go}, 0);
    chk(status == 8'h00, "R1 reset status", status, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R6: mask zero waits for not busy; first reply 0x0C discarded (R3)
    replies = '{8'h01, 8'h00};
    poll(8'h00, 1000);
    chk(done && status == 8'h00, "R6 mask zero done", {done, status}, 9'h100);

    // R6: ready mask, busy+ready not enough
    replies = '{8'h00, 8'h03, 8'h02};
    poll(8'h02, 1000);
    chk(done && status == 8'h02, "R6 ready mask", {done, status}, 9'h102);

    // R5: error bit 3
    replies = '{8'h01, 8'h08};
    poll(8'h00, 1000);
    chk(err && !done, "R5 error bit3", {err, done}, 2'b10);

    // R5: violation bit wins over success with mask 0x04
    replies = '{8'h04};
    poll(8'h04, 1000);
    chk(err && status == 8'h04, "R5 priority", {err, status}, 9'h104);

    // R7: always busy
    replies.delete();
    poll(8'h00, 1000);
    chk(tmo && status == 8'h01, "R7 timeout", {tmo, status}, 9'h101);

    // R9: flag sticks until next start
    repeat (5) @(negedge clk);
    chk(tmo && !active, "R9 flag sticky", tmo, 1);

    // R2: start while active and mask change are ignored
    replies = '{8'h01, 8'h01, 8'h00};
    @(negedge clk); start = 1; mask = 8'h00;
    @(negedge clk); start = 0; mask = 8'hFF;
    repeat (6) @(negedge clk);
    start = 1; mask = 8'h02;
    @(negedge clk); start = 0;
    for (int i = 0; i < 1000 && m_act; i++) @(negedge clk);
    @(negedge clk);
    chk(done && status == 8'h00, "R2 restart ignored", {done, status}, 9'h100);

    // R2: new start clears flag
    replies = '{8'h01, 8'h01};
    @(negedge clk); start = 1; mask = 8'h00;
    @(negedge clk); start = 0;
    chk(active && !done, "R2 flags cleared", {active, done}, 2'b10);
    for (int i = 0; i < 1000 && m_act; i++) @(negedge clk);
    @(negedge clk);
    chk(tmo, "R7 timeout second", tmo, 1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule